// File: doc/BRIEF.md
# Linked Descriptor DMA Sequencer

This block is the control half of a single DMA channel. Software places a chain of eight-word descriptors in memory and writes the address of the first one into the channel. It then sets the run bit in the control word. The sequencer reads each descriptor with eight single-word reads and passes the transfer fields to a separate data mover. When the mover reports that it is finished and no writes are still outstanding, the sequencer follows the descriptor's link word.

A link value of zero ends the chain. At that point the current-descriptor register reads zero, and this zero is the true idle indication, because the run bit keeps reading 1. A link that points back to an earlier descriptor makes an endless ring, which suits streaming buffers. The channel sets a done flag after every descriptor. It also raises an interrupt after each descriptor whose info word has bit 0 set.

Software uses the control word for three further actions: it can pause the channel, skip the descriptor in progress, or reset the whole channel. Reads of the control word also report the pending-write and error status.

Top module: `dma_chain_seq`

## Requirements
- R1: A descriptor is eight 32-bit words: info, source, destination, length, stride, link, and two reserved words. They are read one word per memory read at the descriptor address plus 4·k for k = 0 to 7, in order. Register index 1 holds the descriptor address, and the low 5 bits of any descriptor address are forced to zero. Register indices 2 to 7 read back the stored info, source, destination, length, stride and link words.
- R2: After the eighth word has arrived, `mover_start` pulses for exactly one cycle, with the info, source, destination, length and stride words on the mover outputs.
- R3: The channel moves to the next descriptor only after `mover_done` has been seen and `mover_wr_pending` is low. The descriptor address then becomes the link word with its low 5 bits cleared.
- R4: When the link word is zero, the descriptor address becomes 0 and the channel idles with no further fetches or starts. Control bit 0 still reads 1.
- R5: Control bit 1 is set at the end of every descriptor. Control bit 2 is set at the end of a descriptor whose info bit 0 is 1. `irq` always equals control bit 2.
- R6: Writing 1 to control bit 2 clears it, and writing 1 to control bit 1 clears it. Control bit 0 takes the written value, so writing 0x5 clears the interrupt and keeps the channel running.
- R7: While control bit 0 is 0, the channel makes no memory read, no mover start and no advance to the next descriptor. Control bit 4 reads as the inverse of bit 0, and writing 1 to bit 0 resumes where the channel stopped.
- R8: Writing 1 to control bit 30 while a descriptor is loaded abandons that descriptor and goes to its link word without setting bit 1 or bit 2. Bit 30 reads 0.
- R9: Writing 1 to control bit 31 resets the channel in the next cycle: the control word reads 0x10 (apart from bit 6), the address and stored words are 0, and `irq` is low. Bit 31 reads 0.
- R10: Control bit 6 follows `mover_wr_pending`. Control bit 8 is set by a `mover_err` pulse and stays set until a reset.
- R11: A link word that points back to an earlier descriptor makes the channel loop without end, raising `irq` on each pass through a descriptor that has interrupts enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index (0 control, 1 descriptor address, 2-7 stored fields) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| mover_start | output | 1 | One-cycle start pulse to the data mover |
| mover_info | output | 32 | Info word |
| mover_src | output | 32 | Source address |
| mover_dst | output | 32 | Destination address |
| mover_len | output | 32 | Transfer length |
| mover_stride | output | 32 | Stride word |
| mover_done | input | 1 | Mover finished pulse |
| mover_wr_pending | input | 1 | Mover still has writes outstanding |
| mover_err | input | 1 | Mover error pulse |
| irq | output | 1 | Interrupt line |

## Verification
The hardest condition to reach is a descriptor whose mover has signalled done while writes are still outstanding. This window must be long enough to observe that the address does not advance. The stub mover keeps its pending output high for a programmable number of cycles after done, so the bench widens that window to 20 cycles and reads the registers inside it. A sweep over chain lengths 1 to 4 and every pattern of interrupt-enable bits covers the ordering and flag logic. It also puts junk in the low link bits, which exercises the alignment masking.

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int ALIGN  = 5,
  parameter int NWORDS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        mover_start,
  output logic [31:0] mover_info,
  output logic [31:0] mover_src,
  output logic [31:0] mover_dst,
  output logic [31:0] mover_len,
  output logic [31:0] mover_stride,
  input  logic        mover_done,
  input  logic        mover_wr_pending,
  input  logic        mover_err,
  output logic        irq
);
  localparam int CW = $clog2(NWORDS);
  localparam logic [31:0] LOWMASK = (32'd1 << ALIGN) - 32'd1;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_START, S_BUSY} st_t;

  st_t         st;
  logic [31:0] cb_q;
  logic [31:0] dw [NWORDS];
  logic [CW-1:0] wcnt;
  logic        act, endf, intf, errf, done_seen;

  wire cs_wr    = reg_we && reg_idx == 3'd0;
  wire soft_rst = cs_wr && reg_wdata[31];
  wire loaded   = st == S_START || st == S_BUSY;
  wire skip     = cs_wr && reg_wdata[30] && loaded;
  wire finish   = st == S_BUSY && done_seen && !mover_wr_pending && act;
  wire [31:0] nxt = dw[5] & ~LOWMASK;

  assign mem_req      = st == S_FETCH && act;
  assign mem_addr     = cb_q | {{(32-CW-2){1'b0}}, wcnt, 2'b00};
  assign mover_start  = st == S_START && act;
  assign mover_info   = dw[0];
  assign mover_src    = dw[1];
  assign mover_dst    = dw[2];
  assign mover_len    = dw[3];
  assign mover_stride = dw[4];
  assign irq          = intf;

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      st <= S_IDLE;
      cb_q <= '0;
      wcnt <= '0;
      act <= 1'b0;
      endf <= 1'b0;
      intf <= 1'b0;
      errf <= 1'b0;
      done_seen <= 1'b0;
      for (int i = 0; i < NWORDS; i++) dw[i] <= '0;
    end else begin
      if (mover_err) errf <= 1'b1;
      if (cs_wr) begin
        act <= reg_wdata[0];
        if (reg_wdata[1]) endf <= 1'b0;
        if (reg_wdata[2]) intf <= 1'b0;
      end
      if (reg_we && reg_idx == 3'd1) cb_q <= reg_wdata & ~LOWMASK;
      case (st)
        S_IDLE:  if (act && cb_q != '0) begin st <= S_FETCH; wcnt <= '0; end
        S_FETCH: if (mem_ack) begin
                   dw[wcnt] <= mem_rdata;
                   wcnt <= wcnt + 1'b1;
                   if (wcnt == CW'(NWORDS-1)) st <= S_START;
                 end
        S_START: if (act) begin st <= S_BUSY; done_seen <= 1'b0; end
        S_BUSY:  if (mover_done) done_seen <= 1'b1;
        default: st <= S_IDLE;
      endcase
      if (finish || skip) begin
        cb_q <= nxt;
        st <= (nxt != '0) ? S_FETCH : S_IDLE;
        wcnt <= '0;
        done_seen <= 1'b0;
      end
      if (finish) begin
        endf <= 1'b1;
        if (dw[0][0]) intf <= 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_idx)
      3'd0:    reg_rdata = {23'd0, errf, 1'b0, mover_wr_pending, 1'b0, ~act, 1'b0, intf, endf, act};
      3'd1:    reg_rdata = cb_q;
      default: reg_rdata = dw[reg_idx - 3'd2];
    endcase
  end

  AST_FETCH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> cb_q != '0); // R1
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mover_start |=> !mover_start); // R2
  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n) (st == S_BUSY && mover_wr_pending && !reg_we) |=> $stable(cb_q)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (st == S_IDLE) |-> !mover_start); // R4
  AST_IRQ_WITH_END: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> endf); // R5
  AST_PAUSE_STILL: assert property (@(posedge clk) disable iff (!rst_n) !act |-> (!mover_start && !mem_req)); // R7
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n) soft_rst |=> (cb_q == '0 && !irq)); // R9
endmodule

// File: tb/dma_chain_seq_bench.sv
module dma_chain_seq_bench;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic reg_we = 0; logic [2:0] reg_idx = 0; logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_ack = 0; logic [31:0] mem_addr, mem_rdata = 0;
  logic mover_start, mover_done = 0, mover_err = 0, irq;
  logic [31:0] mover_info, mover_src, mover_dst, mover_len, mover_stride;
  logic wr_pend;

  dma_chain_seq u_dma_chain_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .mover_start(mover_start), .mover_info(mover_info),
    .mover_src(mover_src), .mover_dst(mover_dst), .mover_len(mover_len),
    .mover_stride(mover_stride), .mover_done(mover_done), .mover_wr_pending(wr_pend),
    .mover_err(mover_err), .irq(irq));

  logic [31:0] mem [256];
  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    mem_rdata <= mem[mem_addr[9:2]];
  end

  int pend_cyc = 2, mv_cnt = 0, pd_cnt = 0, nstart = 0;
  logic [31:0] log_src [64];
  always @(posedge clk) begin
    mover_done <= 1'b0;
    if (!rst_n) begin mv_cnt <= 0; pd_cnt <= 0; end
    else if (mover_start) begin
      mv_cnt <= int'(mover_len[15:2]) + 2; pd_cnt <= 0;
      log_src[nstart % 64] <= mover_src; nstart <= nstart + 1;
    end else if (mv_cnt > 0) begin
      mv_cnt <= mv_cnt - 1;
      if (mv_cnt == 1) begin mover_done <= 1'b1; pd_cnt <= pend_cyc; end
    end else if (pd_cnt > 0) pd_cnt <= pd_cnt - 1;
  end
  assign wr_pend = mv_cnt > 0 || pd_cnt > 0;

  int n_chk = 0, n_fail = 0;
  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin n_fail++; $display("FAIL %s actual=%h expected=%h", r, a, e); end
  endtask
  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_idx = i; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask
  task automatic rd(input logic [2:0] i, output logic [31:0] d);
    @(negedge clk); reg_idx = i; #1 d = reg_rdata;
  endtask
  task automatic put_desc(input int b, input logic [31:0] info, src, len, nx);
    mem[b/4+0] = info; mem[b/4+1] = src; mem[b/4+2] = src + 32'h8000; mem[b/4+3] = len;
    mem[b/4+4] = 0; mem[b/4+5] = nx; mem[b/4+6] = 32'hdead; mem[b/4+7] = 32'hbeef;
  endtask
  task automatic wait_idle(input string r);
    logic [31:0] v; int k;
    for (k = 0; k < 6000; k++) begin rd(1, v); if (v == 0) break; end
    if (k == 6000) chk({r, " idle timeout"}, 1, 0);
  endtask
  task automatic wait_starts(input int t, input string r);
    int k;
    for (k = 0; k < 6000 && nstart < t; k++) @(negedge clk);
    if (nstart < t) chk({r, " start timeout"}, nstart, t);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v; int ns0, icount, k;
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    rd(0, v); chk("R9 reset cs", v, 32'h10);
    rd(1, v); chk("R9 reset addr", v, 0);
    chk("R5 reset irq", irq, 0);

    // R1 R2 R4 R5 sweep: chain length x interrupt-enable pattern
    for (int n = 1; n <= 4; n++) begin
      for (int m = 0; m < (1 << n); m++) begin
        for (int d = 0; d < n; d++)
          put_desc(64*(d+1), {31'd0, m[d]}, (n << 12) | (m << 4) | d, 4*(d+1),
                   (d == n-1) ? 32'd0 : (64*(d+2) | 32'h0b));
        wr(0, 6); wr(1, 32'h40 | 32'h13);
        rd(1, v); chk("R1 address low bits masked", v, 32'h40);
        ns0 = nstart; wr(0, 1);
        wait_idle("R4 sweep");
        chk("R2 start count", nstart - ns0, n);
        for (int d = 0; d < n; d++)
          chk("R1 descriptor order", log_src[(ns0 + d) % 64], (n << 12) | (m << 4) | d);
        rd(0, v); chk("R5 flags at end", v, 32'h3 | ((m != 0) ? 32'h4 : 32'h0));
        chk("R5 irq", irq, (m != 0));
        rd(2, v); chk("R1 stored info", v, {31'd0, m[n-1]});
        rd(7, v); chk("R1 stored link", v, 0);
        repeat (20) @(negedge clk);
        chk("R4 no refetch", nstart - ns0, n);
      end
    end

    // R3 R10: advance held while writes pending
    pend_cyc = 20;
    put_desc(32'h40, 0, 32'h111, 8, 32'h80); put_desc(32'h80, 0, 32'h222, 8, 0);
    wr(0, 6); wr(1, 32'h40); ns0 = nstart; wr(0, 1);
    wait_starts(ns0 + 1, "R3");
    for (k = 0; k < 500 && !mover_done; k++) @(negedge clk);
    repeat (5) @(negedge clk);
    rd(0, v); chk("R10 pending bit6", v[6], 1);
    rd(1, v); chk("R3 address held while pending", v, 32'h40);
    chk("R3 no early start", nstart - ns0, 1);
    wait_idle("R3");
    chk("R3 second start", nstart - ns0, 2);
    pend_cyc = 2;

    // R7 pause and resume
    put_desc(32'h40, 0, 32'h333, 32'h100, 32'h80); put_desc(32'h80, 0, 32'h444, 8, 0);
    wr(0, 6); wr(1, 32'h40); ns0 = nstart; wr(0, 1);
    wait_starts(ns0 + 1, "R7");
    wr(0, 0);
    repeat (150) @(negedge clk);
    chk("R7 no start while paused", nstart - ns0, 1);
    rd(1, v); chk("R7 address held while paused", v, 32'h40);
    rd(0, v); chk("R7 bit4 paused", v[4], 1);
    wr(0, 1);
    wait_idle("R7");
    chk("R7 resumed", nstart - ns0, 2);
    chk("R7 resumed src", log_src[(ns0 + 1) % 64], 32'h444);

    // R11 R6 ring
    put_desc(32'h40, 1, 32'h555, 8, 32'h80); put_desc(32'h80, 0, 32'h666, 8, 32'h40);
    wr(0, 6); wr(1, 32'h40); ns0 = nstart; wr(0, 1);
    icount = 0;
    for (int p = 0; p < 4; p++) begin
      for (k = 0; k < 3000 && !irq; k++) @(negedge clk);
      if (irq) icount++;
      wr(0, 5);
      chk("R6 irq cleared", irq, 0);
      rd(0, v); chk("R6 still active", v[0], 1);
    end
    chk("R11 ring interrupts", icount, 4);
    chk("R11 ring keeps starting", (nstart - ns0) >= 7, 1);

    // R10 error flag, then R9 soft reset
    @(negedge clk); mover_err = 1; @(negedge clk); mover_err = 0;
    rd(0, v); chk("R10 error bit8", v[8], 1);
    wr(0, 32'h8000_0000);
    rd(0, v); chk("R9 cs after reset", v & ~32'h40, 32'h10);
    rd(1, v); chk("R9 addr after reset", v, 0);
    rd(2, v); chk("R9 stored info cleared", v, 0);
    chk("R9 irq after reset", irq, 0);
    ns0 = nstart; repeat (100) @(negedge clk);
    chk("R9 stopped", nstart - ns0, 0);

    // R8 abort current descriptor
    put_desc(32'hc0, 1, 32'h777, 32'h200, 32'h100); put_desc(32'h100, 0, 32'h888, 8, 0);
    wr(0, 6); wr(1, 32'hc0); ns0 = nstart; wr(0, 1);
    wait_starts(ns0 + 1, "R8");
    wr(0, 32'h4000_0001);
    rd(0, v); chk("R8 bit30 reads 0", v[30], 0);
    wait_idle("R8");
    chk("R8 next started", log_src[(ns0 + 1) % 64], 32'h888);
    rd(0, v); chk("R8 no interrupt from skipped", v, 32'h3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule